// File: doc/BRIEF.md
# Channel Address Interleave Remover

This block turns a system address into a channel-local address for a memory channel that has already been chosen. It holds eight programmable target rules. Each rule gives an address window, the socket and channel way counts, the bit positions where each interleave applies, and one offset word per channel. A request carries the system address and the channel index. The block finds the first rule whose window holds the address and subtracts that rule's offset for the channel. It then removes the socket and channel interleaves by dividing the part of the address above each interleave bit by the way count, keeping the bits below it.

Rules are loaded through a simple write port, one field group per write. Requests and responses use valid/ready handshakes, with one request in flight at a time. Way counts of 1, 2, 4 and 8 are removed with a shift in one cycle. A way count of 3 goes through a bit-serial restoring divider, and `busy` is high while that divider runs.

Top module: `chanIlvRemover`

## Requirements
- R1: During and right after reset, `reqReady` is 1, `rspValid` is 0 and `busy` is 0.
- R2: Rule n covers the addresses from its base to its limit, both ends included. The base is the base word bits [31:12] shifted left by 26. The limit is the ways word bits [31:12] shifted left by 26, with bits [25:0] all ones. When several rules match, the lowest-numbered one is used.
- R3: `rspMiss` is 1 when no rule matches or when `reqChan` is 3 or more. For a miss, `rspValid` rises two cycles after the request is accepted.
- R4: The running channel address starts as the request address minus the selected offset. The offset is the offset word bits [23:4] of the matched rule and requested channel, shifted left by 26, with the result taken modulo 2^46.
- R5: `rspSktWays` equals 1 shifted left by ways word bits [11:10]. `rspChnWays` equals ways word bits [9:8] plus one.
- R6: Base word bits [5:4] select the socket interleave bit and bits [7:6] select the channel interleave bit. The codes 0, 1, 2 and 3 select bit 6, 8, 12 and 30.
- R7: Removing one interleave at bit s with w ways gives ((x >> s) / w) << s, OR-ed with bits [s-1:0] of a low-bit source.
- R8: When the channel ways are 3 and the socket bit is above the channel bit, the channel interleave is removed first and the socket interleave second. Both steps take their low bits from the running value.
- R9: In every other case the socket interleave is removed first and the channel interleave second. Both steps take their low bits from the request address.
- R10: A request that needs no division by 3 gets `rspValid` three cycles after acceptance, and `busy` stays 0. A request with 3 channel ways raises `busy` and responds later.
- R11: `reqReady` is 0 from acceptance until the response is taken. While `rspValid` is 1 and `rspReady` is 0, all response fields hold steady.
- R12: `cfgKind` selects the field group a write updates: 0 = base word, 1 = ways word, 2 = offset word for (`cfgRule`, `cfgChan`). Kind 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Rule write strobe |
| cfgKind | input | 2 | Field group to write (0 base, 1 ways, 2 offset, 3 none) |
| cfgRule | input | 3 | Rule index to write |
| cfgChan | input | 2 | Channel index for offset writes |
| cfgData | input | 32 | Write data word |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 46 | System address |
| reqChan | input | 2 | Target channel index |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Consumer takes the response |
| rspMiss | output | 1 | No rule matched or channel out of range |
| rspChanAddr | output | 46 | Channel-local address |
| rspSktWays | output | 4 | Socket way count |
| rspChnWays | output | 3 | Channel way count |
| busy | output | 1 | Divide-by-3 in progress |

## Verification
A wrong rule selection or offset shows up in the first response, as a wrong `rspChanAddr` or a spurious `rspMiss`. That response arrives two or three cycles after acceptance. A wrong removal order or low-bit source only shows when the two interleave bits differ and the low bits of the running value and the request address differ. So the rules are built so that some have the socket bit at 30 and offsets that change bits 26 to 29. A stuck divider or sequencer shows at once as a missing or late `rspValid`, a `busy` that does not clear, or a `reqReady` that does not come back.

// File: rtl/chanIlvPkg.sv
package chanIlvPkg;

  // Low bits below every rule boundary and offset step
  localparam int BLK_SH = 26;
  localparam int FLD_W = 20;

  typedef enum logic [1:0] {
    CFG_BASE = 2'd0,
    CFG_WAYS = 2'd1,
    CFG_OFFS = 2'd2,
    CFG_NONE = 2'd3
  } cfgKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic apply;
    logic divStart;
    logic stepSel;
  } ctrlStrb_t;

  // Fields of the selected rule handed to the datapath
  typedef struct packed {
    logic [1:0]       sktGran;
    logic [1:0]       chnGran;
    logic [1:0]       sktLog;
    logic [1:0]       chnFld;
    logic [FLD_W-1:0] ofsFld;
  } ruleSel_t;

  function automatic logic [5:0] granBit(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd6;
      2'd1:    return 6'd8;
      2'd2:    return 6'd12;
      default: return 6'd30;
    endcase
  endfunction

endpackage

// File: rtl/chanIlvRuleTable.sv
module chanIlvRuleTable
  import chanIlvPkg::*;
#(
  parameter int ADDR_W    = 46,
  parameter int NUM_RULES = 8,
  parameter int NUM_CHAN  = 3,
  parameter int REG_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [1:0]           cfgKind,
  input  logic [$clog2(NUM_RULES)-1:0] cfgRule,
  input  logic [(NUM_CHAN > 1 ? $clog2(NUM_CHAN) : 1)-1:0] cfgChan,
  input  logic [REG_W-1:0]     cfgData,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [(NUM_CHAN > 1 ? $clog2(NUM_CHAN) : 1)-1:0] reqChan,
  output logic                 hit,
  output ruleSel_t             sel
);

  localparam int IDX_W = $clog2(NUM_RULES);
  localparam int CH_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
  localparam logic [CH_W:0] NCH = (CH_W+1)'(NUM_CHAN);
  localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'((64'd1 << BLK_SH) - 64'd1);

  logic [FLD_W-1:0] baseFld [NUM_RULES];
  logic [FLD_W-1:0] limFld  [NUM_RULES];
  logic [1:0]       sktGran [NUM_RULES];
  logic [1:0]       chnGran [NUM_RULES];
  logic [1:0]       sktLog  [NUM_RULES];
  logic [1:0]       chnFld  [NUM_RULES];
  logic [FLD_W-1:0] ofsFld  [NUM_RULES][NUM_CHAN];

  logic unusedCfg;
  assign unusedCfg = ^{cfgData[11:8], cfgData[7:0], cfgData[3:0], cfgData[31:24]};

  logic cfgChanOk;
  assign cfgChanOk = {1'b0, cfgChan} < NCH;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_RULES; r++) begin
        baseFld[r] <= '0;
        limFld[r]  <= '0;
        sktGran[r] <= '0;
        chnGran[r] <= '0;
        sktLog[r]  <= '0;
        chnFld[r]  <= '0;
        for (int c = 0; c < NUM_CHAN; c++) ofsFld[r][c] <= '0;
      end
    end else if (cfgWe) begin
      case (cfgKind_e'(cfgKind))
        CFG_BASE: begin
          baseFld[cfgRule] <= cfgData[31:12];
          chnGran[cfgRule] <= cfgData[7:6];
          sktGran[cfgRule] <= cfgData[5:4];
        end
        CFG_WAYS: begin
          limFld[cfgRule] <= cfgData[31:12];
          sktLog[cfgRule] <= cfgData[11:10];
          chnFld[cfgRule] <= cfgData[9:8];
        end
        CFG_OFFS: begin
          if (cfgChanOk) ofsFld[cfgRule][cfgChan] <= cfgData[23:4];
        end
        default: ;
      endcase
    end
  end

  logic [NUM_RULES-1:0] ruleHit;

  for (genvar g = 0; g < NUM_RULES; g++) begin : gMatch
    logic [ADDR_W-1:0] loAddr;
    logic [ADDR_W-1:0] hiAddr;
    assign loAddr = ADDR_W'(baseFld[g]) << BLK_SH;
    assign hiAddr = (ADDR_W'(limFld[g]) << BLK_SH) | LOW_ONES;
    assign ruleHit[g] = (reqAddr >= loAddr) && (reqAddr <= hiAddr);
  end

  logic [IDX_W-1:0] selRule;
  logic             anyHit;

  always_comb begin
    selRule = '0;
    anyHit  = 1'b0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (ruleHit[i]) begin
        selRule = IDX_W'(i);
        anyHit  = 1'b1;
      end
    end
  end

  logic reqChanOk;
  assign reqChanOk = {1'b0, reqChan} < NCH;
  assign hit = anyHit && reqChanOk;

  always_comb begin
    sel.sktGran = sktGran[selRule];
    sel.chnGran = chnGran[selRule];
    sel.sktLog  = sktLog[selRule];
    sel.chnFld  = chnFld[selRule];
    sel.ofsFld  = reqChanOk ? ofsFld[selRule][reqChan] : '0;
  end

endmodule

// File: rtl/chanIlvSerialDiv.sv
module chanIlvSerialDiv #(
  parameter int W       = 46,
  parameter int DIVISOR = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  output logic [W-1:0] quotient,
  output logic         busy,
  output logic         done
);

  localparam int RW = $clog2(DIVISOR) + 1;
  localparam int CW = $clog2(W + 1);
  localparam logic [RW:0] DIV_V = (RW+1)'(DIVISOR);

  logic [W-1:0]  work;
  logic [RW-1:0] rem;
  logic [CW-1:0] cnt;
  logic          doneR;

  logic [RW:0] trial;
  logic        fits;
  logic [RW:0] trialSub;
  assign trial    = {rem, work[W-1]};
  assign fits     = trial >= DIV_V;
  assign trialSub = trial - DIV_V;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      work  <= '0;
      rem   <= '0;
      cnt   <= '0;
      doneR <= 1'b0;
    end else if (start) begin
      work  <= dividend;
      rem   <= '0;
      cnt   <= CW'(W);
      doneR <= 1'b0;
    end else if (cnt != '0) begin
      rem   <= fits ? trialSub[RW-1:0] : trial[RW-1:0];
      work  <= {work[W-2:0], fits};
      cnt   <= cnt - CW'(1);
      doneR <= (cnt == CW'(1));
    end else begin
      doneR <= 1'b0;
    end
  end

  assign quotient = work;
  assign busy     = cnt != '0;
  assign done     = doneR;

endmodule

// File: rtl/chanIlvDatapath.sv
module chanIlvDatapath
  import chanIlvPkg::*;
#(
  parameter int ADDR_W = 46,
  parameter int SKT_W  = 4,
  parameter int CHW_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              hit,
  input  ruleSel_t          sel,
  output logic              needDiv,
  output logic              divDone,
  output logic              miss,
  output logic              busy,
  output logic [ADDR_W-1:0] chanAddr,
  output logic [SKT_W-1:0]  sktWays,
  output logic [CHW_W-1:0]  chnWays
);

  logic [ADDR_W-1:0] origAddr;
  logic [ADDR_W-1:0] runAddr;
  logic              missR;
  logic [1:0]        sktGranR;
  logic [1:0]        chnGranR;
  logic [1:0]        sktLogR;
  logic [1:0]        chnFldR;

  logic [5:0]        sktBit;
  logic [5:0]        chnBit;
  logic              chnFirst;
  logic              chanStep;
  logic [5:0]        stepShift;
  logic [1:0]        stepLog;
  logic [ADDR_W-1:0] lowSrc;
  logic [ADDR_W-1:0] hiPart;
  logic [ADDR_W-1:0] divQuo;
  logic [ADDR_W-1:0] quo;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] stepRes;
  logic [ADDR_W-1:0] ofsAddr;

  assign sktBit    = granBit(sktGranR);
  assign chnBit    = granBit(chnGranR);
  assign chnFirst  = (chnFldR == 2'd2) && (sktBit > chnBit);
  assign chanStep  = strb.stepSel ? !chnFirst : chnFirst;
  assign stepShift = chanStep ? chnBit : sktBit;
  assign stepLog   = chanStep ? ((chnFldR == 2'd3) ? 2'd2 : chnFldR) : sktLogR;
  assign lowSrc    = chnFirst ? runAddr : origAddr;
  assign hiPart    = runAddr >> stepShift;
  assign needDiv   = chanStep && (chnFldR == 2'd2);
  assign quo       = needDiv ? divQuo : (hiPart >> stepLog);
  assign lowMask   = ~({ADDR_W{1'b1}} << stepShift);
  assign stepRes   = (quo << stepShift) | (lowSrc & lowMask);
  assign ofsAddr   = ADDR_W'(sel.ofsFld) << BLK_SH;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      origAddr <= '0;
      runAddr  <= '0;
      missR    <= 1'b0;
      sktGranR <= '0;
      chnGranR <= '0;
      sktLogR  <= '0;
      chnFldR  <= '0;
    end else if (strb.load) begin
      origAddr <= reqAddr;
      runAddr  <= reqAddr - ofsAddr;
      missR    <= !hit;
      sktGranR <= sel.sktGran;
      chnGranR <= sel.chnGran;
      sktLogR  <= sel.sktLog;
      chnFldR  <= sel.chnFld;
    end else if (strb.apply) begin
      runAddr <= stepRes;
    end
  end

  chanIlvSerialDiv #(
    .W      (ADDR_W),
    .DIVISOR(3)
  ) uDiv (
    .clk     (clk),
    .rstN    (rstN),
    .start   (strb.divStart),
    .dividend(hiPart),
    .quotient(divQuo),
    .busy    (busy),
    .done    (divDone)
  );

  assign miss     = missR;
  assign chanAddr = runAddr;
  assign sktWays  = SKT_W'(1) << sktLogR;
  assign chnWays  = CHW_W'(chnFldR) + CHW_W'(1);

endmodule

// File: rtl/chanIlvCtrl.sv
module chanIlvCtrl
  import chanIlvPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      rspValid,
  input  logic      rspReady,
  input  logic      miss,
  input  logic      needDiv,
  input  logic      divDone,
  output ctrlStrb_t strb
);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_DIVW, S_RESP} state_e;

  state_e state, nxtState;
  logic   stepIdx, nxtIdx;

  always_comb begin
    nxtState     = state;
    nxtIdx       = stepIdx;
    strb         = '0;
    strb.stepSel = stepIdx;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          nxtState  = S_STEP;
          nxtIdx    = 1'b0;
        end
      end
      S_STEP: begin
        if (miss) begin
          nxtState = S_RESP;
        end else if (needDiv) begin
          strb.divStart = 1'b1;
          nxtState      = S_DIVW;
        end else begin
          strb.apply = 1'b1;
          if (stepIdx) nxtState = S_RESP;
          else nxtIdx = 1'b1;
        end
      end
      S_DIVW: begin
        if (divDone) begin
          strb.apply = 1'b1;
          if (stepIdx) begin
            nxtState = S_RESP;
          end else begin
            nxtIdx   = 1'b1;
            nxtState = S_STEP;
          end
        end
      end
      default: begin
        if (rspReady) nxtState = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepIdx <= 1'b0;
    end else begin
      state   <= nxtState;
      stepIdx <= nxtIdx;
    end
  end

  assign reqReady = state == S_IDLE;
  assign rspValid = state == S_RESP;

endmodule

// File: rtl/chanIlvRemover.sv
module chanIlvRemover
  import chanIlvPkg::*;
#(
  parameter int ADDR_W    = 46,
  parameter int NUM_RULES = 8,
  parameter int NUM_CHAN  = 3,
  parameter int REG_W     = 32,
  parameter int SKT_W     = 4,
  parameter int CHW_W     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [1:0]           cfgKind,
  input  logic [$clog2(NUM_RULES)-1:0] cfgRule,
  input  logic [(NUM_CHAN > 1 ? $clog2(NUM_CHAN) : 1)-1:0] cfgChan,
  input  logic [REG_W-1:0]     cfgData,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [(NUM_CHAN > 1 ? $clog2(NUM_CHAN) : 1)-1:0] reqChan,
  output logic                 rspValid,
  input  logic                 rspReady,
  output logic                 rspMiss,
  output logic [ADDR_W-1:0]    rspChanAddr,
  output logic [SKT_W-1:0]     rspSktWays,
  output logic [CHW_W-1:0]     rspChnWays,
  output logic                 busy
);

  ctrlStrb_t strb;
  ruleSel_t  sel;
  logic      hit;
  logic      needDiv;
  logic      divDone;
  logic      miss;

  chanIlvRuleTable #(
    .ADDR_W   (ADDR_W),
    .NUM_RULES(NUM_RULES),
    .NUM_CHAN (NUM_CHAN),
    .REG_W    (REG_W)
  ) uTable (
    .clk    (clk),
    .rstN   (rstN),
    .cfgWe  (cfgWe),
    .cfgKind(cfgKind),
    .cfgRule(cfgRule),
    .cfgChan(cfgChan),
    .cfgData(cfgData),
    .reqAddr(reqAddr),
    .reqChan(reqChan),
    .hit    (hit),
    .sel    (sel)
  );

  chanIlvCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .rspValid(rspValid),
    .rspReady(rspReady),
    .miss    (miss),
    .needDiv (needDiv),
    .divDone (divDone),
    .strb    (strb)
  );

  chanIlvDatapath #(
    .ADDR_W(ADDR_W),
    .SKT_W (SKT_W),
    .CHW_W (CHW_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .hit     (hit),
    .sel     (sel),
    .needDiv (needDiv),
    .divDone (divDone),
    .miss    (miss),
    .busy    (busy),
    .chanAddr(rspChanAddr),
    .sktWays (rspSktWays),
    .chnWays (rspChnWays)
  );

  assign rspMiss = miss;

endmodule

// File: rtl/chanIlvChk.sv
module chanIlvChk #(
  parameter int ADDR_W = 46,
  parameter int SKT_W  = 4,
  parameter int CHW_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspReady,
  input logic              rspMiss,
  input logic [ADDR_W-1:0] rspChanAddr,
  input logic [SKT_W-1:0]  rspSktWays,
  input logic [CHW_W-1:0]  rspChnWays,
  input logic              busy
);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspChanAddr) && $stable(rspMiss)
      && $stable(rspSktWays) && $stable(rspChnWays));

  // R11
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady && !rspValid);

  // R10
  no_busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !busy && !rspValid);

  // R5
  ways_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspMiss |-> $countones(rspSktWays) == 1 && rspChnWays != '0
      && rspChnWays <= CHW_W'(4));

endmodule

bind chanIlvRemover chanIlvChk #(
  .ADDR_W(ADDR_W),
  .SKT_W (SKT_W),
  .CHW_W (CHW_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .rspValid   (rspValid),
  .rspReady   (rspReady),
  .rspMiss    (rspMiss),
  .rspChanAddr(rspChanAddr),
  .rspSktWays (rspSktWays),
  .rspChnWays (rspChnWays),
  .busy       (busy)
);

// File: tb/tb_chanIlvRemover.sv
module tb_chanIlvRemover;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgKind = '0;
  logic [2:0]  cfgRule = '0;
  logic [1:0]  cfgChan = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [45:0] reqAddr = '0;
  logic [1:0]  reqChan = '0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic        rspMiss;
  logic [45:0] rspChanAddr;
  logic [3:0]  rspSktWays;
  logic [2:0]  rspChnWays;
  logic        busy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  chanIlvRemover dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgRule(cfgRule),
    .cfgChan(cfgChan), .cfgData(cfgData), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqChan(reqChan), .rspValid(rspValid), .rspReady(rspReady),
    .rspMiss(rspMiss), .rspChanAddr(rspChanAddr), .rspSktWays(rspSktWays),
    .rspChnWays(rspChnWays), .busy(busy)
  );

  // Shadow of the rule words as written
  logic [31:0] mBase [8];
  logic [31:0] mWay  [8];
  logic [31:0] mOfs  [8][3];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !finished) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <180000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int gmap(input logic [1:0] c);
    case (c)
      2'd0: return 6;
      2'd1: return 8;
      2'd2: return 12;
      default: return 30;
    endcase
  endfunction

  function automatic logic [45:0] strip(input logic [45:0] x, input int sh, input int ways,
                                        input logic [45:0] low);
    logic [63:0] hv;
    logic [45:0] msk;
    hv  = {18'b0, x} >> sh;
    hv  = hv / ways;
    hv  = hv << sh;
    msk = (46'd1 << sh) - 46'd1;
    return hv[45:0] | (low & msk);
  endfunction

  // Reference from the requirements; returns 1 when a division by 3 is due
  function automatic bit model(input logic [45:0] a, input int ch, output bit miss,
                               output logic [45:0] ca, output int sw, output int cw);
    int r = -1;
    logic [45:0] lo, hi, run;
    int sb, cb;
    for (int i = 7; i >= 0; i--) begin
      lo = {6'b0, mBase[i][31:12], 20'b0} << 6;
      hi = ({6'b0, mWay[i][31:12], 20'b0} << 6) | 46'h3FF_FFFF;
      if (a >= lo && a <= hi) r = i;
    end
    miss = (r < 0) || (ch >= 3);
    ca = '0; sw = 0; cw = 0;
    if (miss) return 1'b0;
    run = a - ({26'b0, mOfs[r][ch][23:4]} << 26);
    sw = 1 << mWay[r][11:10];
    cw = int'(mWay[r][9:8]) + 1;
    sb = gmap(mBase[r][5:4]);
    cb = gmap(mBase[r][7:6]);
    if (cw == 3 && sb > cb) begin
      ca = strip(run, cb, cw, run);
      ca = strip(ca, sb, sw, ca);
    end else begin
      ca = strip(run, sb, sw, a);
      ca = strip(ca, cb, cw, a);
    end
    return cw == 3;
  endfunction

  task automatic cfgWrite(input logic [1:0] k, input int r, input int ch, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgKind = k; cfgRule = 3'(r); cfgChan = 2'(ch); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (k == 2'd0) mBase[r] = d;
    else if (k == 2'd1) mWay[r] = d;
    else if (k == 2'd2 && ch < 3) mOfs[r][ch] = d;
  endtask

  function automatic logic [31:0] mkBase(input int bf, input int sg, input int cg);
    return {20'(bf), 4'h0, 2'(cg), 2'(sg), 4'h0};
  endfunction
  function automatic logic [31:0] mkWay(input int lf, input int sl, input int cf);
    return {20'(lf), 2'(sl), 2'(cf), 8'h00};
  endfunction
  function automatic logic [31:0] mkOfs(input int of);
    return {8'h00, 20'(of), 4'h0};
  endfunction

  task automatic setRule(input int r, input int bf, input int lf, input int sg, input int cg,
                         input int sl, input int cf);
    cfgWrite(2'd0, r, 0, mkBase(bf, sg, cg));
    cfgWrite(2'd1, r, 0, mkWay(lf, sl, cf));
    for (int c = 0; c < 3; c++) cfgWrite(2'd2, r, c, mkOfs(int'($urandom % (bf + 1))));
  endtask

  task automatic runReq(input logic [45:0] a, input int ch, input string tag, input int hold);
    bit expMiss, expDiv, sawBusy;
    logic [45:0] expAddr, capAddr;
    int expSw, expCw, lat;
    expDiv = model(a, ch, expMiss, expAddr, expSw, expCw);
    @(negedge clk);
    if (hold > 0) rspReady = 1'b0;
    reqValid = 1'b1; reqAddr = a; reqChan = 2'(ch);
    while (!reqReady) @(negedge clk);
    lat = 0; sawBusy = 1'b0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) reqValid = 1'b0;
      sawBusy |= busy;
    end while (!rspValid && lat < 400);
    chk(rspValid, {tag, " R10 response arrives"}, 64'(lat), 64'd0);
    chk(rspMiss == expMiss, {tag, " R3 miss flag"}, 64'(rspMiss), 64'(expMiss));
    if (!expMiss) begin
      chk(rspChanAddr == expAddr, {tag, " R7 channel address"}, 64'(rspChanAddr), 64'(expAddr));
      chk(rspSktWays == 4'(expSw) && rspChnWays == 3'(expCw), {tag, " R5 way counts"},
          {32'(rspSktWays), 32'(rspChnWays)}, {32'(expSw), 32'(expCw)});
      if (expDiv)
        chk(sawBusy && lat > 3, {tag, " R10 divide path busy"}, 64'(lat), 64'd4);
      else
        chk(!sawBusy && lat == 3, {tag, " R10 shift path latency"}, 64'(lat), 64'd3);
    end else begin
      chk(lat == 2, {tag, " R3 miss latency"}, 64'(lat), 64'd2);
    end
    if (hold > 0) begin
      capAddr = rspChanAddr;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(rspValid && !reqReady && rspChanAddr == capAddr, {tag, " R11 response held"},
            {17'b0, rspValid, rspChanAddr}, {17'b0, 1'b1, capAddr});
      end
      rspReady = 1'b1;
      @(negedge clk);
      chk(!rspValid && reqReady, {tag, " R11 released"}, 64'({rspValid, reqReady}), 64'b01);
    end
  endtask

  initial begin
    logic [45:0] a, lo, hi;
    logic [63:0] span;
    int r, ch;
    void'($urandom(32'd4021));
    for (int i = 0; i < 8; i++) begin
      mBase[i] = '0; mWay[i] = '0;
      for (int c = 0; c < 3; c++) mOfs[i][c] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(reqReady == 1'b1 && rspValid == 1'b0 && busy == 1'b0, "R1 reset outputs",
        64'({reqReady, rspValid, busy}), 64'b100);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && rspValid == 1'b0 && busy == 1'b0, "R1 after reset",
        64'({reqReady, rspValid, busy}), 64'b100);

    // Random rule set; gaps between windows
    for (int i = 0; i < 8; i++) begin
      int bf;
      bf = i * 64 + 1 + int'($urandom % 8);
      setRule(i, bf, bf + 4 + int'($urandom % 40), int'($urandom % 4), int'($urandom % 4),
              int'($urandom % 4), int'($urandom % 4));
    end

    // R2 window edges on rule 0
    lo = {6'b0, mBase[0][31:12], 20'b0} << 6;
    hi = ({6'b0, mWay[0][31:12], 20'b0} << 6) | 46'h3FF_FFFF;
    runReq(lo, 0, "R2 base edge", 0);
    runReq(hi, 1, "R2 limit edge", 0);
    runReq(hi + 46'd1, 0, "R2 past limit", 0);
    runReq(lo - 46'd1, 2, "R2 below base", 0);

    // R4 plain offset: one way each, bit 6
    setRule(7, 7 * 64 + 2, 7 * 64 + 30, 0, 0, 0, 0);
    a = ({6'b0, 20'(7 * 64 + 5), 20'b0} << 6) + 46'h123_4567;
    runReq(a, 1, "R4 offset only", 0);
    chk(rspChanAddr == a - ({26'b0, mOfs[7][1][23:4]} << 26), "R4 subtract",
        64'(rspChanAddr), 64'(a - ({26'b0, mOfs[7][1][23:4]} << 26)));

    // R8 channel first: 3 ways, socket bit 30 above channel bit 6
    setRule(3, 3 * 64 + 1, 3 * 64 + 60, 3, 0, 1, 2);
    runReq(({6'b0, 20'(3 * 64 + 9), 20'b0} << 6) + 46'h2ABC_DEF5, 2, "R8 chan-first", 0);
    // R9 socket first with division, socket bit 6 below channel bit 30
    setRule(4, 4 * 64 + 1, 4 * 64 + 60, 0, 3, 2, 2);
    runReq(({6'b0, 20'(4 * 64 + 11), 20'b0} << 6) + 46'h1F0F_0F0F, 0, "R9 skt-first div", 0);
    // R9 equal bits, 3 ways
    setRule(6, 6 * 64 + 1, 6 * 64 + 60, 1, 1, 3, 2);
    runReq(({6'b0, 20'(6 * 64 + 13), 20'b0} << 6) + 46'h0777_7777, 1, "R9 equal bits", 0);
    // R6 code 2 socket, code 3 channel, 8 socket ways
    setRule(1, 1 * 64 + 1, 1 * 64 + 60, 2, 3, 3, 3);
    runReq(({6'b0, 20'(1 * 64 + 7), 20'b0} << 6) + 46'h3FFF_F0C0, 0, "R6 gran codes", 0);

    // R2 priority: rule 5 copies rule 2 window with other ways
    cfgWrite(2'd0, 5, 0, mkBase(int'(mBase[2][31:12]), 3, 2));
    cfgWrite(2'd1, 5, 0, mkWay(int'(mWay[2][31:12]), 2, 1));
    runReq({6'b0, mBase[2][31:12], 20'b0} << 6, 0, "R2 lowest rule wins", 0);

    // R12 ignored write kind
    cfgWrite(2'd3, 1, 0, 32'hFFFF_FFFF);
    runReq(({6'b0, 20'(1 * 64 + 7), 20'b0} << 6) + 46'h0ABC_0001, 2, "R12 kind 3 no effect", 0);

    // R3 channel index 3
    runReq(({6'b0, 20'(1 * 64 + 7), 20'b0} << 6), 3, "R3 channel out of range", 0);
    runReq(46'h3FFF_FFFF_FFFF, 0, "R3 above all rules", 0);

    // R11 hold with stalled consumer, divide and shift paths
    runReq(({6'b0, 20'(3 * 64 + 9), 20'b0} << 6) + 46'h55, 0, "R11 hold div", 4);
    runReq(({6'b0, 20'(7 * 64 + 9), 20'b0} << 6) + 46'h99, 0, "R11 hold shift", 3);

    // Random traffic, R7 through all rules
    for (int n = 0; n < 250; n++) begin
      r  = int'($urandom % 8);
      ch = ($urandom % 16 == 0) ? 3 : int'($urandom % 3);
      lo = {6'b0, mBase[r][31:12], 20'b0} << 6;
      hi = ({6'b0, mWay[r][31:12], 20'b0} << 6) | 46'h3FF_FFFF;
      span = 64'(hi - lo) + 64'd1;
      a = lo + 46'({$urandom, $urandom} % span);
      if ($urandom % 20 == 0) a = {$urandom, $urandom} % 46'h3FFF_FFFF_FFFF;
      runReq(a, ch, "R7 random", ($urandom % 10 == 0) ? 2 : 0);
    end

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule